// File: doc/BRIEF.md
# Timestamped Input Pattern Capture

This block conditions one group of 16 discriminator inputs and turns activity on them into timestamped capture items. Each input is first gated by its own enable bit and optionally inverted; in the variant built with a stretcher, every conditioned input can also be lengthened by a programmable count of 50 ns steps. The conditioned vector is exported so that a sibling group can use it for coincidence.

A small mode word picks how items are formed. In transition mode every clock compares the conditioned inputs with the previous clock, and newly risen bits form the item; the group gate can optionally qualify all inputs. In gated mode the timestamp is frozen at the leading edge of the gate, every input seen high while the gate is open is ORed into an accumulator, and the item leaves when the gate closes. In coincidence mode the pattern is the bitwise AND of this group with the sibling group, and each new coincidence is an item. Items leave through a valid/ready port; an item that finds the port occupied is dropped and a sticky overflow flag is raised.

Top module: `pcap_group`

## Requirements
- R1: An input whose enable bit is 0 never contributes to any item, while enabled neighbours still do.
- R2: An input whose invert bit is 1 is complemented before any detection, so a falling edge at the pin is what produces its item.
- R3: Transition mode (mode bit 0): an input driven high before clock edge k gives an item valid after edge k+1, with the pattern holding exactly the newly risen bits, kind 0 (hit), and the timestamp equal to `ts_now` at edge k+1; an input that stays high gives no further item.
- R4: With `cfg_gate_and` set in transition mode, inputs count only while the group gate is high.
- R5: Gated mode (mode bit 1): the timestamp is `ts_now` one edge after the gate is registered high, the pattern is the OR of all inputs seen high while the gate was registered high, and the item (kind 1, end) becomes valid two edges after the gate is driven low; nothing is emitted while the gate is open.
- R6: Coincidence mode (mode bit 2): the pattern bit n is conditioned input n AND `peer_cond[n]`, and each new rising of that product gives its own hit item.
- R7: With the stretcher built and mode bit 3 set, a rising conditioned input stays high for `cfg_stretch`×5 clocks from its first registered cycle; a new rising edge restarts the count; a value of 0 passes the input unchanged.
- R8: An item whose pattern would be all zeros is never emitted, in every mode (including a gate that closes with nothing accumulated).
- R9: A valid item holds its pattern, timestamp and kind until `cap_ready` is 1; a new item arriving while an item is held and not being taken is dropped and `ovf` is set and stays set until reset.
- R10: Mode priority is gated over coincidence over transition; with none of bits 0 to 2 set no item is produced.
- R11: After reset `cap_valid`, `ovf` and `cond_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_in | input | 16 | Group discriminator inputs |
| gate_in | input | 1 | Group gate |
| peer_cond | input | 16 | Sibling group's conditioned inputs |
| ts_now | input | 48 | Running timestamp counter |
| cfg_enable | input | 16 | Per-input enable |
| cfg_invert | input | 16 | Per-input invert |
| cfg_mode | input | 4 | Bit 0 transition, bit 1 gated, bit 2 coincidence, bit 3 stretch |
| cfg_gate_and | input | 1 | Qualify inputs with the gate in transition mode |
| cfg_stretch | input | 4 | Stretch length in 5-clock steps |
| cond_out | output | 16 | Conditioned inputs for the sibling group |
| cap_valid | output | 1 | Item available |
| cap_ready | input | 1 | Downstream takes the item |
| cap_pattern | output | 16 | Item pattern |
| cap_ts | output | 48 | Item timestamp |
| cap_kind | output | 1 | 0 hit, 1 gate end |
| ovf | output | 1 | Sticky dropped-item flag |

## Verification
Inputs pass one register before `cond_out` changes and a second before an item is loaded, so transition and coincidence items are sampled half a clock after the second edge following the input change, and gated items half a clock after the second edge following the gate falling. Stretch length is measured by counting the falling-edge samples in which `cond_out` is high. Each scenario task drives on falling edges, steps the exact edge count derived above and compares there, and absence checks are taken at the same point where an item would otherwise appear.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
    typedef enum logic {
        KIND_HIT = 1'b0,
        KIND_END = 1'b1
    } cap_kind_e;

    localparam int MODE_TRANS   = 0;
    localparam int MODE_GATED   = 1;
    localparam int MODE_COIN    = 2;
    localparam int MODE_STRETCH = 3;
    localparam int MODE_W       = 4;
endpackage

// File: rtl/pcap_stretch.sv
module pcap_stretch #(
    parameter int STW  = 4,
    parameter int STEP = 5,
    localparam int CW  = $clog2(((2 ** STW) - 1) * STEP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           raw_i,
    input  logic           rise_i,
    input  logic           on_i,
    input  logic [STW-1:0] len_i,
    output logic           out_o
);
    logic [CW-1:0] len_cyc;
    logic [CW-1:0] cnt_d, cnt_q;

    assign len_cyc = CW'(len_i) * CW'(STEP);

    always_comb begin
        cnt_d = cnt_q;
        if (!on_i) begin
            cnt_d = '0;
        end else if (rise_i) begin
            cnt_d = len_cyc;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign out_o = raw_i | (on_i & (cnt_q != '0));

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on_i && rise_i && len_i != '0 && $stable(on_i)) |=> out_o);
endmodule

// File: rtl/pcap_cond.sv
module pcap_cond #(
    parameter int N          = 16,
    parameter int STW        = 4,
    parameter int STEP       = 5,
    parameter bit STRETCH_EN = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   grp_i,
    input  logic [N-1:0]   en_i,
    input  logic [N-1:0]   inv_i,
    input  logic           stretch_on_i,
    input  logic [STW-1:0] len_i,
    output logic [N-1:0]   cond_o
);
    logic [N-1:0] raw_d, raw_q, rise;

    always_comb begin
        raw_d = (grp_i ^ inv_i) & en_i;
        rise  = raw_d & ~raw_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    generate
        if (STRETCH_EN) begin : g_stretch
            for (genvar i = 0; i < N; i++) begin : g_bit
                pcap_stretch #(.STW(STW), .STEP(STEP)) u_st (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .raw_i  (raw_q[i]),
                    .rise_i (rise[i]),
                    .on_i   (stretch_on_i),
                    .len_i  (len_i),
                    .out_o  (cond_o[i])
                );
            end
        end else begin : g_plain
            assign cond_o = raw_q;
        end
    endgenerate
endmodule

// File: rtl/pcap_detect.sv
module pcap_detect
    import pcap_pkg::*;
#(
    parameter int N  = 16,
    parameter int TW = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      cond_i,
    input  logic [N-1:0]      peer_i,
    input  logic              gate_i,
    input  logic [TW-1:0]     ts_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              gate_and_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [N-1:0]      pat_o,
    output logic [TW-1:0]     ts_o,
    output cap_kind_e         kind_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic          gate_q;
        logic          gate_prev;
        logic [N-1:0]  trans_prev;
        logic [N-1:0]  coin_prev;
        logic [N-1:0]  acc;
        logic [TW-1:0] ts_hold;
        logic          valid;
        logic [N-1:0]  pat;
        logic [TW-1:0] ts;
        cap_kind_e     kind;
        logic          ovf;
    } det_t;

    det_t st_d, st_q;

    logic          m_gated, m_coin, m_trans;
    logic          gate_rise, gate_fall;
    logic [N-1:0]  qual_in, trans_hits, coin_vec, coin_hits;
    logic          fire;
    logic [N-1:0]  f_pat;
    logic [TW-1:0] f_ts;
    cap_kind_e     f_kind;

    always_comb begin
        m_gated = mode_i[MODE_GATED];
        m_coin  = mode_i[MODE_COIN] & ~m_gated;
        m_trans = mode_i[MODE_TRANS] & ~m_gated & ~mode_i[MODE_COIN];

        gate_rise  = st_q.gate_q & ~st_q.gate_prev;
        gate_fall  = ~st_q.gate_q & st_q.gate_prev;
        qual_in    = cond_i & (gate_and_i ? {N{st_q.gate_q}} : {N{1'b1}});
        trans_hits = qual_in & ~st_q.trans_prev;
        coin_vec   = cond_i & peer_i;
        coin_hits  = coin_vec & ~st_q.coin_prev;

        st_d            = st_q;
        st_d.gate_q     = gate_i;
        st_d.gate_prev  = st_q.gate_q;
        st_d.trans_prev = qual_in;
        st_d.coin_prev  = coin_vec;

        if (gate_rise) begin
            st_d.acc     = cond_i;
            st_d.ts_hold = ts_i;
        end else if (st_q.gate_q) begin
            st_d.acc = st_q.acc | cond_i;
        end else if (gate_fall) begin
            st_d.acc = '0;
        end

        fire   = 1'b0;
        f_pat  = '0;
        f_ts   = ts_i;
        f_kind = KIND_HIT;
        if (m_gated) begin
            fire   = gate_fall;
            f_pat  = st_q.acc;
            f_ts   = st_q.ts_hold;
            f_kind = KIND_END;
        end else if (m_coin) begin
            fire  = 1'b1;
            f_pat = coin_hits;
        end else if (m_trans) begin
            fire  = 1'b1;
            f_pat = trans_hits;
        end

        if (ready_i) st_d.valid = 1'b0;
        if (fire && f_pat != '0) begin
            if (!st_q.valid || ready_i) begin
                st_d.valid = 1'b1;
                st_d.pat   = f_pat;
                st_d.ts    = f_ts;
                st_d.kind  = f_kind;
            end else begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= KIND_HIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign pat_o   = st_q.pat;
    assign ts_o    = st_q.ts;
    assign kind_o  = st_q.kind;
    assign ovf_o   = st_q.ovf;

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(pat_o) && $stable(ts_o) && $stable(kind_o)));

    // R8
    nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pat_o != '0));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R5
    end_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid_o) && kind_o == KIND_END) |-> (!st_q.gate_q && st_q.gate_prev == 1'b0));
endmodule

// File: rtl/pcap_group.sv
module pcap_group
    import pcap_pkg::*;
#(
    parameter int N          = 16,
    parameter int TW         = 48,
    parameter int STW        = 4,
    parameter int STEP       = 5,
    parameter bit STRETCH_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      grp_in,
    input  logic              gate_in,
    input  logic [N-1:0]      peer_cond,
    input  logic [TW-1:0]     ts_now,
    input  logic [N-1:0]      cfg_enable,
    input  logic [N-1:0]      cfg_invert,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_gate_and,
    input  logic [STW-1:0]    cfg_stretch,
    output logic [N-1:0]      cond_out,
    output logic              cap_valid,
    input  logic              cap_ready,
    output logic [N-1:0]      cap_pattern,
    output logic [TW-1:0]     cap_ts,
    output logic              cap_kind,
    output logic              ovf
);
    cap_kind_e kind_w;

    pcap_cond #(.N(N), .STW(STW), .STEP(STEP), .STRETCH_EN(STRETCH_EN)) u_cond (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_i        (grp_in),
        .en_i         (cfg_enable),
        .inv_i        (cfg_invert),
        .stretch_on_i (cfg_mode[MODE_STRETCH]),
        .len_i        (cfg_stretch),
        .cond_o       (cond_out)
    );

    pcap_detect #(.N(N), .TW(TW)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond_out),
        .peer_i     (peer_cond),
        .gate_i     (gate_in),
        .ts_i       (ts_now),
        .mode_i     (cfg_mode),
        .gate_and_i (cfg_gate_and),
        .ready_i    (cap_ready),
        .valid_o    (cap_valid),
        .pat_o      (cap_pattern),
        .ts_o       (cap_ts),
        .kind_o     (kind_w),
        .ovf_o      (ovf)
    );

    assign cap_kind = kind_w;
endmodule

// File: tb/tb_pcap_group.sv
module tb_pcap_group;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] grp_in = '0;
    logic        gate_in = 1'b0;
    logic [15:0] peer_cond = '0;
    logic [47:0] ts_now = '0;
    logic [15:0] cfg_enable = '1;
    logic [15:0] cfg_invert = '0;
    logic [3:0]  cfg_mode = 4'd1;
    logic        cfg_gate_and = 1'b0;
    logic [3:0]  cfg_stretch = '0;
    logic [15:0] cond_out;
    logic        cap_valid;
    logic        cap_ready = 1'b0;
    logic [15:0] cap_pattern;
    logic [47:0] cap_ts;
    logic        cap_kind;
    logic        ovf;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcap_group dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run hung, cycle %0d expected < 100000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic pulse(input logic [15:0] bits);
        grp_in = bits;
        step(1);
        grp_in = '0;
    endtask

    task automatic take();
        cap_ready = 1'b1;
        step(1);
        cap_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 valid", cap_valid, 0);
        chk("R11 ovf", ovf, 0);
        chk("R11 cond", cond_out, 0);
    endtask

    task automatic t_transition();
        cfg_mode = 4'd1; ts_now = 48'd100;
        pulse(16'h0005); step(1);
        chk("R3 valid", cap_valid, 1);
        chk("R3 pattern", cap_pattern, 16'h0005);
        chk("R3 ts", cap_ts, 100);
        chk("R3 kind", cap_kind, 0);
        take();
        grp_in = 16'h0100; ts_now = 48'd101;
        step(2);
        chk("R3 level pattern", cap_pattern, 16'h0100);
        take(); step(3);
        chk("R3 no repeat while high", cap_valid, 0);
        grp_in = '0; step(2);
    endtask

    task automatic t_mask();
        cfg_enable = 16'hFFFE;
        pulse(16'h0001); step(1);
        chk("R1 disabled silent", cap_valid, 0);
        pulse(16'h0003); step(1);
        chk("R1 neighbour kept", cap_pattern, 16'h0002);
        take(); cfg_enable = '1; step(2);
    endtask

    task automatic t_invert();
        grp_in = 16'h0010; cfg_invert = 16'h0010; step(3);
        chk("R2 idle inverted", cap_valid, 0);
        grp_in = '0; step(2);
        chk("R2 falling pin", cap_pattern, 16'h0010);
        chk("R2 valid", cap_valid, 1);
        take(); grp_in = 16'h0010; step(2);
        chk("R2 rising pin silent", cap_valid, 0);
        cfg_invert = '0; grp_in = '0; step(2);
    endtask

    task automatic t_gate_and();
        cfg_gate_and = 1'b1;
        pulse(16'h0002); step(1);
        chk("R4 gate low", cap_valid, 0);
        gate_in = 1'b1; step(2);
        pulse(16'h0004); step(1);
        chk("R4 gate high", cap_pattern, 16'h0004);
        take(); gate_in = 1'b0; cfg_gate_and = 1'b0; step(2);
    endtask

    task automatic t_gated();
        cfg_mode = 4'd2;
        gate_in = 1'b1; ts_now = 48'd200; step(3);
        ts_now = 48'd300;
        pulse(16'h0008); pulse(16'h0080); step(1);
        chk("R5 quiet while open", cap_valid, 0);
        gate_in = 1'b0; ts_now = 48'd400; step(1);
        chk("R5 not before close+2", cap_valid, 0);
        step(1);
        chk("R5 valid", cap_valid, 1);
        chk("R5 pattern", cap_pattern, 16'h0088);
        chk("R5 ts at open", cap_ts, 200);
        chk("R5 kind end", cap_kind, 1);
        take();
        gate_in = 1'b1; step(3); gate_in = 1'b0; step(3);
        chk("R8 empty gate", cap_valid, 0);
    endtask

    task automatic t_coin();
        cfg_mode = 4'd4; peer_cond = 16'h00F0; ts_now = 48'd500;
        pulse(16'h0020); step(1);
        chk("R6 pattern", cap_pattern, 16'h0020);
        chk("R6 ts", cap_ts, 500);
        take();
        pulse(16'h0002); step(1);
        chk("R6 no peer", cap_valid, 0);
        ts_now = 48'd600;
        pulse(16'h0020); step(1);
        chk("R6 second coincidence", cap_ts, 600);
        take(); peer_cond = '0;
    endtask

    task automatic t_stretch();
        int hi;
        cap_ready = 1'b1;
        cfg_mode = 4'd9; cfg_stretch = 4'd2;
        hi = 0;
        grp_in = 16'h0001;
        step(1); hi += int'(cond_out[0]); grp_in = '0;
        for (int i = 0; i < 20; i++) begin step(1); hi += int'(cond_out[0]); end
        chk("R7 length 2x5", hi, 10);
        hi = 0;
        grp_in = 16'h0001;
        step(1); hi += int'(cond_out[0]); grp_in = '0;
        for (int i = 0; i < 4; i++) begin step(1); hi += int'(cond_out[0]); end
        grp_in = 16'h0001;
        step(1); hi += int'(cond_out[0]); grp_in = '0;
        for (int i = 0; i < 20; i++) begin step(1); hi += int'(cond_out[0]); end
        chk("R7 restart", hi, 15);
        cfg_stretch = 4'd0; hi = 0;
        grp_in = 16'h0001;
        step(1); hi += int'(cond_out[0]); grp_in = '0;
        for (int i = 0; i < 5; i++) begin step(1); hi += int'(cond_out[0]); end
        chk("R7 zero passes", hi, 1);
        cfg_mode = 4'd1; cap_ready = 1'b0; step(2);
    endtask

    task automatic t_modes();
        cfg_mode = 4'd0;
        pulse(16'h0001); step(1);
        chk("R10 no mode", cap_valid, 0);
        cfg_mode = 4'd5;
        pulse(16'h0001); step(1);
        chk("R10 coin over trans", cap_valid, 0);
        cfg_mode = 4'd7;
        pulse(16'h0001); step(1);
        chk("R10 gated over all", cap_valid, 0);
        cfg_mode = 4'd1; step(1);
    endtask

    task automatic t_ovf();
        ts_now = 48'd700;
        pulse(16'h0001); step(1);
        chk("R9 first", cap_pattern, 16'h0001);
        ts_now = 48'd800; step(3);
        chk("R9 held ts", cap_ts, 700);
        chk("R9 no ovf yet", ovf, 0);
        pulse(16'h0002); step(1);
        chk("R9 kept first", cap_pattern, 16'h0001);
        chk("R9 ovf set", ovf, 1);
        take();
        chk("R9 released", cap_valid, 0);
        step(2);
        chk("R9 ovf sticky", ovf, 1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_transition();
        t_mask();
        t_invert();
        t_gate_and();
        t_gated();
        t_coin();
        t_stretch();
        t_modes();
        t_ovf();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule